// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits next to a simple 32-bit CPU pipeline and decides, each cycle, whether the pipeline has to leave its normal flow. Seven request lines arrive together: the reset event, address fault, undefined-opcode fault, floating-point fault, software trap (with a 4-bit trap number), system break and external interrupt. The controller also receives the PC of the current instruction and the PC of the one after it. It grants the single most urgent pending event. It computes the handler entry address and stores the correct resume address in a backup PC register. It also saves the status word into a shadow field and clears interrupt-enable.

Entry completes in the cycle it is requested: the grant, cause code and entry address are combinational, and the backup PC and the status registers update at the next clock edge. A return command reverses the status save. It also presents the resume address, which is the backup PC forced to a word boundary. The CPU can write the status word directly when neither an entry nor a return is under way.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several requests are active together, the grant goes to exactly one of them, ranked highest first: reset event, address fault, undefined-opcode fault, floating-point fault, trap, system break, external interrupt. The `cause` output encodes the granted event as: 0 none, 1 reset event, 2 address fault, 3 undefined opcode, 4 floating-point, 5 trap, 6 system break, 7 external interrupt.
- R2: On an address fault or an undefined-opcode fault, the backup PC takes `cur_pc` at the next clock edge.
- R3: On a floating-point fault or a trap, the backup PC takes `cur_pc + 4` at the next clock edge.
- R4: On a system break or an external interrupt, the backup PC takes `next_pc` at the next clock edge.
- R5: A granted trap drives `vec_addr` to 0x40 + 4 × `trap_num`, so trap numbers 0..15 cover 0x40..0x7C.
- R6: The fixed entry addresses are: reset event 0x00, system break 0x10, undefined opcode 0x20, address fault 0x30, external interrupt 0x80, floating-point 0x90.
- R7: An external interrupt is ignored while status bit 6 (interrupt-enable) is 0. In that case `accept` stays low and the backup PC and both status registers keep their values.
- R8: `accept` and `vec_valid` are high in the same cycle as the granting request. At the next edge the shadow status takes the old status word, and status bit 6 becomes 0.
- R9: A return command with no grant in the same cycle raises `ret_valid` that cycle. `ret_pc` then equals the backup PC with bits 1:0 cleared, and at the next edge the status word is reloaded from the shadow status.
- R10: In a cycle with a grant, a simultaneous return command or status write has no effect: `ret_valid` stays low, and the status follows the entry rule.
- R11: After the hardware reset (`rst_n` low), the backup PC, status and shadow status are all zero, and no grant is given while the request lines are idle.
- R12: A granted reset event drives the entry address to 0x00 and clears the whole status word at the next edge. It still copies the old status into the shadow field, and the value it leaves in the backup PC is unspecified.
- R13: A status write (`stat_we`) with no grant and no return loads `stat_wdata` into the status word at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_reset | input | 1 | Reset event request |
| req_addr_exc | input | 1 | Address fault request |
| req_rsv_instr | input | 1 | Undefined-opcode fault request |
| req_fp_exc | input | 1 | Floating-point fault request |
| req_trap | input | 1 | Software trap request |
| trap_num | input | 4 | Trap number for the trap request |
| req_sys_break | input | 1 | System break request |
| req_ext_irq | input | 1 | External interrupt request |
| cur_pc | input | 32 | PC of the instruction in flight |
| next_pc | input | 32 | PC of the following instruction |
| rte_req | input | 1 | Return-from-exception command |
| stat_we | input | 1 | Status word write strobe |
| stat_wdata | input | 8 | Status word write data |
| accept | output | 1 | An event is granted this cycle |
| vec_valid | output | 1 | `vec_addr` is valid this cycle |
| vec_addr | output | 32 | Handler entry address |
| cause | output | 3 | Code of the granted event |
| bpc_q | output | 32 | Backup PC register |
| status_q | output | 8 | Status word |
| bstatus_q | output | 8 | Shadow status field |
| ret_valid | output | 1 | Return accepted this cycle |
| ret_pc | output | 32 | Word-aligned resume address |

## Verification
A wrong priority chain shows up at once as the wrong `cause` and `vec_addr` in the cycle of the request. A bad resume-address choice appears on `bpc_q` one edge later. A status save that loses or fails to clear interrupt-enable appears on `status_q` and `bstatus_q` one edge after entry. It then shows again as a masked or unmasked external interrupt on a later stimulus. A broken restore is seen on `status_q` the edge after a return, and a missing alignment is seen on `ret_pc` in the return cycle itself.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_EV  = 7;
  localparam int CAUSE_W = 3;

  // request index: lower index wins
  localparam int EV_RESET = 0;
  localparam int EV_ADDR  = 1;
  localparam int EV_RSVD  = 2;
  localparam int EV_FPE   = 3;
  localparam int EV_TRAP  = 4;
  localparam int EV_SBI   = 5;
  localparam int EV_EI    = 6;

  // cause code = request index + 1
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_RESET = 3'd1,
    CAUSE_ADDR  = 3'd2,
    CAUSE_RSVD  = 3'd3,
    CAUSE_FPE   = 3'd4,
    CAUSE_TRAP  = 3'd5,
    CAUSE_SBI   = 3'd6,
    CAUSE_EI    = 3'd7
  } cause_e;

  localparam logic [31:0] VEC_RESET     = 32'h0000_0000;
  localparam logic [31:0] VEC_SBI       = 32'h0000_0010;
  localparam logic [31:0] VEC_RSVD      = 32'h0000_0020;
  localparam logic [31:0] VEC_ADDR      = 32'h0000_0030;
  localparam logic [31:0] VEC_TRAP_BASE = 32'h0000_0040;
  localparam logic [31:0] VEC_EI        = 32'h0000_0080;
  localparam logic [31:0] VEC_FPE       = 32'h0000_0090;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ie,
  output logic [N-1:0] grant,
  output cause_e       cause,
  output logic         any
);
  logic [N-1:0] req_m;
  logic [N:0]   seen;

  always_comb begin
    req_m        = req;
    req_m[EV_EI] = req[EV_EI] & ie;
  end

  assign seen[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      assign grant[g]  = req_m[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req_m[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    cause = CAUSE_NONE;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) cause = cause_e'(CAUSE_W'(k + 1));
    end
  end

  // R1: never more than one winner
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7: masked interrupt never wins
  a_r7_ei_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req[EV_EI] && !ie) |-> !grant[EV_EI]);
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cause_e            cause,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [PC_W-1:0]   bpc,
  output logic [PC_W-1:0]   vec_addr,
  output logic [PC_W-1:0]   bpc_next,
  output logic [PC_W-1:0]   ret_pc
);
  localparam int             NUM_TRAPS = 1 << TRAP_W;
  localparam logic [PC_W-1:0] TRAP_LAST =
    PC_W'(VEC_TRAP_BASE) + PC_W'(4 * (NUM_TRAPS - 1));

  function automatic logic [PC_W-1:0] entry_vector(cause_e c, logic [TRAP_W-1:0] tn);
    case (c)
      CAUSE_RESET: return PC_W'(VEC_RESET);
      CAUSE_ADDR:  return PC_W'(VEC_ADDR);
      CAUSE_RSVD:  return PC_W'(VEC_RSVD);
      CAUSE_FPE:   return PC_W'(VEC_FPE);
      CAUSE_TRAP:  return PC_W'(VEC_TRAP_BASE) + PC_W'({tn, 2'b00});
      CAUSE_SBI:   return PC_W'(VEC_SBI);
      CAUSE_EI:    return PC_W'(VEC_EI);
      default:     return '0;
    endcase
  endfunction

  // canceled: retry the instruction; completed: skip it; async: resume at next
  function automatic logic [PC_W-1:0] resume_addr(cause_e c, logic [PC_W-1:0] cur,
                                                  logic [PC_W-1:0] nxt);
    case (c)
      CAUSE_ADDR, CAUSE_RSVD: return cur;
      CAUSE_FPE, CAUSE_TRAP:  return cur + PC_W'(4);
      CAUSE_SBI, CAUSE_EI:    return nxt;
      CAUSE_RESET:            return cur;
      default:                return '0;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] word_align(logic [PC_W-1:0] a);
    return {a[PC_W-1:2], 2'b00};
  endfunction

  assign vec_addr = entry_vector(cause, trap_num);
  assign bpc_next = resume_addr(cause, cur_pc, next_pc);
  assign ret_pc   = word_align(bpc);

  // R5: trap entry stays in its word-spaced window
  a_r5_trap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CAUSE_TRAP) |-> (vec_addr >= PC_W'(VEC_TRAP_BASE) &&
                               vec_addr <= TRAP_LAST && vec_addr[1:0] == 2'b00));
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int PC_W   = 32,
  parameter int STAT_W = 8,
  parameter int IE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry,
  input  logic              reset_ev,
  input  logic [PC_W-1:0]   bpc_next,
  input  logic              rte_go,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [PC_W-1:0]   bpc_q,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] bstatus_q
);
  localparam logic [STAT_W-1:0] IE_MASK = STAT_W'(1) << IE_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpc_q     <= '0;
      status_q  <= '0;
      bstatus_q <= '0;
    end else if (entry) begin
      bpc_q     <= bpc_next;
      bstatus_q <= status_q;
      status_q  <= reset_ev ? '0 : (status_q & ~IE_MASK);
    end else if (rte_go) begin
      status_q  <= bstatus_q;
    end else if (stat_we) begin
      status_q  <= stat_wdata;
    end
  end

  // R8: interrupts are masked after every entry
  a_r8_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !status_q[IE_BIT]);

  // R8: shadow status holds the pre-entry status word
  a_r8_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> bstatus_q == $past(status_q));

  // R9: return reloads status from the shadow
  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_go && !entry) |=> status_q == $past(bstatus_q));

  // R13: idle write lands in status
  a_r13_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !entry && !rte_go) |=> status_q == $past(stat_wdata));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TRAP_W = 4,
  parameter int STAT_W = 8,
  parameter int IE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_addr_exc,
  input  logic              req_rsv_instr,
  input  logic              req_fp_exc,
  input  logic              req_trap,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              req_sys_break,
  input  logic              req_ext_irq,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic              rte_req,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              accept,
  output logic              vec_valid,
  output logic [PC_W-1:0]   vec_addr,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]   bpc_q,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] bstatus_q,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_pc
);
  logic [NUM_EV-1:0] req_vec;
  logic [NUM_EV-1:0] grant;
  cause_e            win_cause;
  logic              any_grant;
  logic [PC_W-1:0]   bpc_next;
  logic              rte_go;

  always_comb begin
    req_vec           = '0;
    req_vec[EV_RESET] = req_reset;
    req_vec[EV_ADDR]  = req_addr_exc;
    req_vec[EV_RSVD]  = req_rsv_instr;
    req_vec[EV_FPE]   = req_fp_exc;
    req_vec[EV_TRAP]  = req_trap;
    req_vec[EV_SBI]   = req_sys_break;
    req_vec[EV_EI]    = req_ext_irq;
  end

  exc_arbiter #(.N(NUM_EV)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_vec),
    .ie    (status_q[IE_BIT]),
    .grant (grant),
    .cause (win_cause),
    .any   (any_grant)
  );

  exc_vector #(.PC_W(PC_W), .TRAP_W(TRAP_W)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause    (win_cause),
    .trap_num (trap_num),
    .cur_pc   (cur_pc),
    .next_pc  (next_pc),
    .bpc      (bpc_q),
    .vec_addr (vec_addr),
    .bpc_next (bpc_next),
    .ret_pc   (ret_pc)
  );

  assign rte_go = rte_req & ~any_grant;

  exc_state #(.PC_W(PC_W), .STAT_W(STAT_W), .IE_BIT(IE_BIT)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry      (any_grant),
    .reset_ev   (grant[EV_RESET]),
    .bpc_next   (bpc_next),
    .rte_go     (rte_go),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .bpc_q      (bpc_q),
    .status_q   (status_q),
    .bstatus_q  (bstatus_q)
  );

  assign accept    = any_grant;
  assign vec_valid = any_grant;
  assign cause     = win_cause;
  assign ret_valid = rte_go;

  // R2: canceled instructions are retried
  a_r2_cancel_bpc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cause == CAUSE_ADDR || cause == CAUSE_RSVD)) |=> bpc_q == $past(cur_pc));

  // R4: asynchronous events resume at the following instruction
  a_r4_next_bpc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cause == CAUSE_SBI || cause == CAUSE_EI)) |=> bpc_q == $past(next_pc));

  // R10: a grant suppresses a return in the same cycle
  a_r10_rte_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_req && accept) |=> !status_q[IE_BIT]);
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_reset = 0, req_addr_exc = 0, req_rsv_instr = 0, req_fp_exc = 0;
  logic        req_trap = 0, req_sys_break = 0, req_ext_irq = 0;
  logic [3:0]  trap_num = '0;
  logic [31:0] cur_pc = '0, next_pc = '0;
  logic        rte_req = 0, stat_we = 0;
  logic [7:0]  stat_wdata = '0;
  logic        accept, vec_valid, ret_valid;
  logic [31:0] vec_addr, bpc_q, ret_pc;
  logic [2:0]  cause;
  logic [7:0]  status_q, bstatus_q;

  always #HALF clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_addr_exc(req_addr_exc),
    .req_rsv_instr(req_rsv_instr), .req_fp_exc(req_fp_exc), .req_trap(req_trap),
    .trap_num(trap_num), .req_sys_break(req_sys_break), .req_ext_irq(req_ext_irq),
    .cur_pc(cur_pc), .next_pc(next_pc), .rte_req(rte_req), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .accept(accept), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .cause(cause), .bpc_q(bpc_q), .status_q(status_q),
    .bstatus_q(bstatus_q), .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  typedef struct {
    string       tag;
    logic        acc;
    logic [2:0]  cse;
    logic [31:0] vec;
    logic        retv;
    logic [31:0] rpc;
    logic        chk_bpc;
    logic [31:0] bpc;
    logic [7:0]  st;
    logic [7:0]  bst;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 0;

  // bench model state
  logic [7:0]  m_st = '0, m_bst = '0;
  logic [31:0] m_bpc = '0;
  logic        m_bpc_ok = 1'b1;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, logic rs, logic ae, logic ri, logic fp, logic tr,
                      logic [3:0] tn, logic sb, logic ei, logic [31:0] cur,
                      logic [31:0] nxt, logic rte, logic we, logic [7:0] wd);
    exp_t e;
    logic [31:0] b;
    @(negedge clk);
    req_reset = rs; req_addr_exc = ae; req_rsv_instr = ri; req_fp_exc = fp;
    req_trap = tr; trap_num = tn; req_sys_break = sb; req_ext_irq = ei;
    cur_pc = cur; next_pc = nxt; rte_req = rte; stat_we = we; stat_wdata = wd;
    e.tag = tag; e.vec = '0; e.cse = 3'd0; b = '0;
    if (rs)                  begin e.cse = 3'd1; e.vec = 32'h00; end
    else if (ae)             begin e.cse = 3'd2; e.vec = 32'h30; b = cur; end
    else if (ri)             begin e.cse = 3'd3; e.vec = 32'h20; b = cur; end
    else if (fp)             begin e.cse = 3'd4; e.vec = 32'h90; b = cur + 4; end
    else if (tr)             begin e.cse = 3'd5; e.vec = 32'h40 + 32'(tn) * 4; b = cur + 4; end
    else if (sb)             begin e.cse = 3'd6; e.vec = 32'h10; b = nxt; end
    else if (ei && m_st[6])  begin e.cse = 3'd7; e.vec = 32'h80; b = nxt; end
    e.acc  = (e.cse != 3'd0);
    e.retv = rte && !e.acc;
    e.rpc  = m_bpc & 32'hFFFF_FFFC;
    if (e.acc) begin
      m_bst = m_st;
      m_st  = rs ? 8'h00 : (m_st & 8'hBF);
      m_bpc = b;
      m_bpc_ok = !rs;
    end else if (e.retv) begin
      m_st = m_bst;
    end else if (we) begin
      m_st = wd;
    end
    e.chk_bpc = m_bpc_ok;
    e.bpc = m_bpc; e.st = m_st; e.bst = m_bst;
    exp_q.push_back(e);
  endtask

  // monitor: outputs of the cycle before the edge, registers after it
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "accept", 32'(accept), 32'(e.acc));
        chk(e.tag, "vec_valid", 32'(vec_valid), 32'(e.acc));
        chk(e.tag, "cause", 32'(cause), 32'(e.cse));
        if (e.acc) chk(e.tag, "vec_addr", vec_addr, e.vec);
        chk(e.tag, "ret_valid", 32'(ret_valid), 32'(e.retv));
        if (e.retv) chk(e.tag, "ret_pc", ret_pc, e.rpc);
        @(posedge clk);
        #5;
        if (e.chk_bpc) chk(e.tag, "bpc_q", bpc_q, e.bpc);
        chk(e.tag, "status_q", 32'(status_q), 32'(e.st));
        chk(e.tag, "bstatus_q", 32'(bstatus_q), 32'(e.bst));
      end
    end
  end

  initial begin
    #(2 * HALF * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R11: hardware reset state
    chk("R11", "bpc_q", bpc_q, 32'h0);
    chk("R11", "status_q", 32'(status_q), 32'h0);
    chk("R11", "bstatus_q", 32'(bstatus_q), 32'h0);
    chk("R11", "accept", 32'(accept), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    //           tag    rs ae ri fp tr tn  sb ei cur           next          rte we wd
    step("R13",  0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        0, 1, 8'h45);
    step("R4",   0, 0, 0, 0, 0, 4'd0, 0, 1, 32'h0000_0FFC, 32'h0000_1002, 0, 0, 8'h00);
    step("R9",   0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        1, 0, 8'h00);
    step("R13",  0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        0, 1, 8'h05);
    step("R7",   0, 0, 0, 0, 0, 4'd0, 0, 1, 32'h0000_0A00, 32'h0000_0A04, 0, 0, 8'h00);
    step("R1",   0, 1, 1, 1, 1, 4'd3, 1, 1, 32'h0000_2000, 32'h0000_2004, 0, 0, 8'h00);
    step("R2",   0, 0, 1, 1, 0, 4'd0, 0, 0, 32'h0000_2104, 32'h0000_2108, 0, 0, 8'h00);
    step("R3",   0, 0, 0, 1, 1, 4'd1, 1, 0, 32'h0000_3000, 32'h0000_3004, 0, 0, 8'h00);
    step("R5",   0, 0, 0, 0, 1, 4'd0, 0, 0, 32'h0000_4000, 32'h0000_4004, 0, 0, 8'h00);
    step("R5",   0, 0, 0, 0, 1, 4'd15, 0, 0, 32'h0000_4100, 32'h0000_4104, 0, 0, 8'h00);
    step("R5",   0, 0, 0, 0, 1, 4'd5, 0, 0, 32'h0000_4200, 32'h0000_4204, 0, 0, 8'h00);
    step("R13",  0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        0, 1, 8'h45);
    step("R6",   0, 0, 0, 0, 0, 4'd0, 1, 1, 32'h0000_5004, 32'h0000_5008, 0, 0, 8'h00);
    step("R9",   0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        1, 0, 8'h00);
    step("R10",  0, 0, 0, 0, 1, 4'd2, 0, 0, 32'h0000_6000, 32'h0000_6004, 1, 1, 8'hFF);
    step("R12",  1, 1, 0, 0, 0, 4'd0, 0, 1, 32'h0000_7000, 32'h0000_7004, 0, 0, 8'h00);
    step("R7",   0, 0, 0, 0, 0, 4'd0, 0, 1, 32'h0,        32'h0,        0, 0, 8'h00);
    step("R8",   0, 0, 0, 0, 0, 4'd0, 0, 0, 32'h0,        32'h0,        0, 0, 8'h00);
    @(negedge clk);
    req_ext_irq = 0; req_sys_break = 0; req_trap = 0; req_fp_exc = 0;
    req_rsv_instr = 0; req_addr_exc = 0; req_reset = 0; rte_req = 0; stat_we = 0;
    repeat (4) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule